// File: doc/BRIEF.md
# Thermal Monitor Register and Alarm Unit

This block is the register front of an on-chip temperature sensor. A sensor front end hands it 8-bit temperature codes with a one-cycle valid strobe. When the sensing core is switched on, each accepted code becomes the current reading. The reading it replaces moves into a short history chain. A processor reaches the block through a simple synchronous register bus with byte enables and a combinational read path.

Software sets one shared threshold code and a separate offset for each trip level. Level n trips when the newest reading is at or above threshold plus offset n. The sum is formed one bit wider than a code, so it never wraps. Trips land in sticky status bits spaced four bits apart. A level interrupt output is raised while any tripped level is also enabled. Software clears status by writing a bit mask. The block also shows the factory calibration trim word and a ready flag from the sensor.

Top module: `thermal_alarm_regs`

## Requirements
- R1: After reset the control word reads 0x2 (core off, gain and reference zero), and threshold, offsets, current, history, enable and status registers read 0, with irq low.
- R2: Control at 0x20: bits 1:0 hold a mode code, and the core runs only while that code is 3 (2 is the off code). A 4-bit gain field sits at bits 11:8 and a 5-bit reference field at bits 28:24. Each field is written only when its byte enable (lanes 0, 1, 3) is set, and all other bits read 0.
- R3: Address 0x00 returns the calibration trim input in bits 15:0: first byte in 7:0, second in 15:8. Address 0x28 returns 1 while the sensor ready input is high and 0 while it is low.
- R4: With the core on, a valid code appears at address 0x40 after the next clock edge. With the core off, valid codes leave 0x40 unchanged.
- R5: Each accepted code first shifts the history: 0x60 takes the previous current value, and each history slot at 0x60+4k takes slot k-1. Codes arriving while the core is off shift nothing.
- R6: The threshold at 0x44 and the level offsets at 0x50+4n occupy bits 7:0. They are written only when byte enable lane 0 is set.
- R7: In the cycle after an accepted code, status bit 4n at 0x74 is set if the current code is at or above threshold plus offset n. The sum is computed 9 bits wide, so a sum above 255 never trips.
- R8: Status bits are sticky through later lower codes. Writing 0x78 clears exactly the status bits whose positions (4n) are 1 in the written data, within the enabled byte lanes. Address 0x78 reads 0.
- R9: If a clear write hits a status bit in the same cycle as a new trip of that level, the bit stays set.
- R10: irq is high exactly when the core is on and some status bit 4n at 0x74 has its enable bit 4n at 0x70 set. While the core is off, irq is low and no status bit becomes set.
- R11: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sens_code | input | CODE_W (8) | Temperature code from the front end |
| sens_valid | input | 1 | One-cycle strobe marking a new code |
| sens_ready | input | 1 | Sensor ready flag |
| trim_word | input | 2*CODE_W (16) | Calibration trim bytes |
| irq | output | 1 | Level interrupt |

## Verification
The trip comparators are driven from a table of codes swept across a threshold of 100 with offsets 0, 10, 20 and 30. The sweep sits on and just below each level's boundary, so an off-by-one in the comparison, or a mix-up in which bit belongs to which level, shows up as a wrong status mask. A threshold of 0xF0 with an offset of 0x20 separates 9-bit sums from wrapping 8-bit sums. Codes sent while the core is off, partial clear masks, and a clear timed onto the trip cycle separate the gating, the sticky behaviour and the trip-wins priority from a plain register.

// File: rtl/thm_pkg.sv
package thm_pkg;
   localparam int BUS_W      = 32;
   localparam int LVL_STRIDE = 4;
   localparam int GAIN_LSB   = 8;
   localparam int VREF_LSB   = 24;

   localparam logic [7:0] A_TRIM  = 8'h00;
   localparam logic [7:0] A_CTRL  = 8'h20;
   localparam logic [7:0] A_RDY   = 8'h28;
   localparam logic [7:0] A_CUR   = 8'h40;
   localparam logic [7:0] A_THR   = 8'h44;
   localparam logic [7:0] A_OFS0  = 8'h50;
   localparam logic [7:0] A_HIST0 = 8'h60;
   localparam logic [7:0] A_IEN   = 8'h70;
   localparam logic [7:0] A_ISTAT = 8'h74;
   localparam logic [7:0] A_ICLR  = 8'h78;

   localparam logic [1:0] MODE_ON  = 2'd3;
   localparam logic [1:0] MODE_OFF = 2'd2;
endpackage

// File: rtl/thm_history.sv
module thm_history #(
   parameter int CODE_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shift_en,
   input  logic [CODE_W-1:0]             cur_in,
   output logic [DEPTH-1:0][CODE_W-1:0]  past
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        past[0] <= '0;
            else if (shift_en) past[0] <= cur_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        past[g] <= '0;
            else if (shift_en) past[g] <= past[g-1];
         end
      end
   end
endmodule

// File: rtl/thm_trip.sv
module thm_trip #(
   parameter int CODE_W = 8,
   parameter int N_LVL  = 4
) (
   input  logic                          eval,
   input  logic [CODE_W-1:0]             cur,
   input  logic [CODE_W-1:0]             thr,
   input  logic [N_LVL-1:0][CODE_W-1:0]  offs,
   output logic [N_LVL-1:0]              hit
);
   localparam int SUM_W = CODE_W + 1;

   for (genvar n = 0; n < N_LVL; n++) begin : g_cmp
      logic [SUM_W-1:0] limit;
      assign limit  = {1'b0, thr} + {1'b0, offs[n]};
      assign hit[n] = eval && ({1'b0, cur} >= limit);
   end
endmodule

// File: rtl/thm_stat.sv
module thm_stat #(
   parameter int N_LVL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] hit,
   input  logic [N_LVL-1:0] clr,
   input  logic [N_LVL-1:0] ien,
   input  logic             core_on,
   output logic [N_LVL-1:0] stat,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | hit;
   end

   assign irq = core_on && (|(stat & ien));
endmodule

// File: rtl/thermal_alarm_regs.sv
module thermal_alarm_regs
   import thm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CODE_W     = 8,
   parameter int N_LVL      = 4,
   parameter int HIST_DEPTH = 4,
   parameter int GAIN_W     = 4,
   parameter int VREF_W     = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [3:0]            bus_be,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [CODE_W-1:0]     sens_code,
   input  logic                  sens_valid,
   input  logic                  sens_ready,
   input  logic [2*CODE_W-1:0]   trim_word,
   output logic                  irq
);
   localparam int TRIM_W = 2 * CODE_W;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must reach the 0x78 register");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
      $error("CODE_W must fit byte lane 0");
   end
   if (N_LVL < 1 || N_LVL > 4) begin : g_bad_lvl
      $error("N_LVL must be 1..4");
   end
   if (HIST_DEPTH < 1 || HIST_DEPTH > 4) begin : g_bad_hist
      $error("HIST_DEPTH must be 1..4");
   end
   if (GAIN_W < 1 || GAIN_W > 8 || VREF_W < 1 || VREF_W > 8) begin : g_bad_fld
      $error("control fields must fit one byte lane");
   end

   function automatic logic [ADDR_W-1:0] ra(input logic [7:0] r);
      return ADDR_W'(r);
   endfunction

   logic [1:0]                          mode_q;
   logic [GAIN_W-1:0]                   gain_q;
   logic [VREF_W-1:0]                   vref_q;
   logic [CODE_W-1:0]                   thr_q;
   logic [CODE_W-1:0]                   cur_q;
   logic [N_LVL-1:0][CODE_W-1:0]        off_q;
   logic [N_LVL-1:0]                    ien_q;
   logic [N_LVL-1:0]                    stat;
   logic [N_LVL-1:0]                    hit;
   logic [N_LVL-1:0]                    clr;
   logic [HIST_DEPTH-1:0][CODE_W-1:0]   hist;
   logic                                core_on;
   logic                                take;
   logic                                upd_q;

   assign core_on = (mode_q == MODE_ON);
   assign take    = sens_valid && core_on;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         gain_q <= '0;
         vref_q <= '0;
         thr_q  <= '0;
         off_q  <= '0;
         ien_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == ra(A_CTRL)) begin
            if (bus_be[0])            mode_q <= bus_wdata[1:0];
            if (bus_be[GAIN_LSB / 8]) gain_q <= bus_wdata[GAIN_LSB +: GAIN_W];
            if (bus_be[VREF_LSB / 8]) vref_q <= bus_wdata[VREF_LSB +: VREF_W];
         end
         if (bus_addr == ra(A_THR) && bus_be[0]) thr_q <= bus_wdata[CODE_W-1:0];
         for (int n = 0; n < N_LVL; n++) begin
            if (bus_be[0] && bus_addr == ra(A_OFS0 + 8'(4 * n)))
               off_q[n] <= bus_wdata[CODE_W-1:0];
            if (bus_be[(LVL_STRIDE * n) / 8] && bus_addr == ra(A_IEN))
               ien_q[n] <= bus_wdata[LVL_STRIDE * n];
         end
      end
   end

   // sample capture; the comparison runs one cycle after capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= take;
         if (take) cur_q <= sens_code;
      end
   end

   always_comb begin
      for (int n = 0; n < N_LVL; n++)
         clr[n] = bus_we && (bus_addr == ra(A_ICLR)) &&
                  bus_be[(LVL_STRIDE * n) / 8] && bus_wdata[LVL_STRIDE * n];
   end

   thm_history #(.CODE_W(CODE_W), .DEPTH(HIST_DEPTH)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (take),
      .cur_in   (cur_q),
      .past     (hist)
   );

   thm_trip #(.CODE_W(CODE_W), .N_LVL(N_LVL)) u_trip (
      .eval (upd_q && core_on),
      .cur  (cur_q),
      .thr  (thr_q),
      .offs (off_q),
      .hit  (hit)
   );

   thm_stat #(.N_LVL(N_LVL)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .clr     (clr),
      .ien     (ien_q),
      .core_on (core_on),
      .stat    (stat),
      .irq     (irq)
   );

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ra(A_TRIM)) bus_rdata[TRIM_W-1:0] = trim_word;
      if (bus_addr == ra(A_CTRL)) begin
         bus_rdata[1:0]                  = mode_q;
         bus_rdata[GAIN_LSB +: GAIN_W]   = gain_q;
         bus_rdata[VREF_LSB +: VREF_W]   = vref_q;
      end
      if (bus_addr == ra(A_RDY)) bus_rdata[0]          = sens_ready;
      if (bus_addr == ra(A_CUR)) bus_rdata[CODE_W-1:0] = cur_q;
      if (bus_addr == ra(A_THR)) bus_rdata[CODE_W-1:0] = thr_q;
      for (int n = 0; n < N_LVL; n++) begin
         if (bus_addr == ra(A_OFS0 + 8'(4 * n))) bus_rdata[CODE_W-1:0] = off_q[n];
         if (bus_addr == ra(A_IEN))   bus_rdata[LVL_STRIDE * n] = ien_q[n];
         if (bus_addr == ra(A_ISTAT)) bus_rdata[LVL_STRIDE * n] = stat[n];
      end
      for (int h = 0; h < HIST_DEPTH; h++)
         if (bus_addr == ra(A_HIST0 + 8'(4 * h))) bus_rdata[CODE_W-1:0] = hist[h];
   end
endmodule

// File: rtl/thm_alarm_chk.sv
module thm_alarm_chk
   import thm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CODE_W = 8,
   parameter int N_LVL  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              sens_valid,
   input logic              irq,
   input logic              core_on,
   input logic [CODE_W-1:0] cur_q,
   input logic [CODE_W-1:0] past0,
   input logic [N_LVL-1:0]  stat
);
   logic clr_wr;
   assign clr_wr = bus_we && (bus_addr == ADDR_W'(A_ICLR));

   p_off_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !core_on |-> !irq);

   p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat != '0));

   p_cur_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !core_on |=> $stable(cur_q));

   p_hist_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_valid && core_on) |=> (past0 == $past(cur_q)));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

   p_set_needs_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~$past(stat)) != '0) |-> $past(core_on));
endmodule

bind thermal_alarm_regs thm_alarm_chk #(
   .ADDR_W (ADDR_W),
   .CODE_W (CODE_W),
   .N_LVL  (N_LVL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .sens_valid (sens_valid),
   .irq        (irq),
   .core_on    (core_on),
   .cur_q      (cur_q),
   .past0      (hist[0]),
   .stat       (stat)
);

// File: tb/sim_thermal_alarm_regs.sv
`timescale 1ns/1ps
module sim_thermal_alarm_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  code = '0;
   logic        valid = 1'b0;
   logic        ready = 1'b0;
   logic [15:0] trim = 16'hA55A;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   thermal_alarm_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_be(be),
      .bus_wdata(wdata), .bus_rdata(rdata), .sens_code(code), .sens_valid(valid),
      .sens_ready(ready), .trim_word(trim), .irq(irq)
   );

   // {code, expected status mask} with threshold 100 and offsets 0/10/20/30
   localparam logic [23:0] VEC [9] = '{
      {8'd99,  16'h0000}, {8'd100, 16'h0001}, {8'd109, 16'h0001},
      {8'd110, 16'h0011}, {8'd119, 16'h0011}, {8'd120, 16'h0111},
      {8'd129, 16'h0111}, {8'd130, 16'h1111}, {8'd255, 16'h1111}
   };

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
      @(negedge clk); addr = a; wdata = d; be = b; we = 1'b1;
      @(negedge clk); we = 1'b0; be = '0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic smp(input logic [7:0] c);
      @(negedge clk); code = c; valid = 1'b1;
      @(negedge clk); valid = 1'b0;
   endtask

   initial begin
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      brd(8'h20, r); chk("R1 ctrl", r, 32'h2);
      brd(8'h40, r); chk("R1 cur", r, 0);
      brd(8'h44, r); chk("R1 thr", r, 0);
      brd(8'h74, r); chk("R1 stat", r, 0);
      brd(8'h6C, r); chk("R1 hist3", r, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R3 trim and ready
      brd(8'h00, r); chk("R3 trim", r, 32'h0000A55A);
      brd(8'h28, r); chk("R3 busy", r, 0);
      ready = 1'b1;
      brd(8'h28, r); chk("R3 ready", r, 1);

      // R2 control fields
      bwr(8'h20, 32'hFFFF_FFFF, 4'hF);
      brd(8'h20, r); chk("R2 ctrl mask", r, 32'h1F00_0F03);
      bwr(8'h20, 32'h0000_0002, 4'h1);
      brd(8'h20, r); chk("R2 off keeps fields", r, 32'h1F00_0F02);

      // R4 gating of the current register
      smp(8'd77);
      brd(8'h40, r); chk("R4 off ignored", r, 0);
      bwr(8'h20, 32'h0000_0003, 4'h1);
      smp(8'd50);
      brd(8'h40, r); chk("R4 on capture", r, 50);

      // R5 history chain
      smp(8'd60); smp(8'd70); smp(8'd80);
      brd(8'h40, r); chk("R5 cur", r, 80);
      brd(8'h60, r); chk("R5 past0", r, 70);
      brd(8'h64, r); chk("R5 past1", r, 60);
      brd(8'h68, r); chk("R5 past2", r, 50);
      brd(8'h6C, r); chk("R5 past3", r, 0);

      // R6 threshold and offsets with byte enables
      bwr(8'h44, 32'd100, 4'h0);
      brd(8'h44, r); chk("R6 lane off ignored", r, 0);
      bwr(8'h44, 32'd100, 4'h1);
      brd(8'h44, r); chk("R6 thr", r, 100);
      bwr(8'h50, 32'd0, 4'h1);
      bwr(8'h54, 32'd10, 4'h1);
      bwr(8'h58, 32'd20, 4'h1);
      bwr(8'h5C, 32'd30, 4'h1);
      brd(8'h5C, r); chk("R6 ofs3", r, 30);

      // R7 trip sweep from the table
      for (int i = 0; i < 9; i++) begin
         bwr(8'h78, 32'h1111, 4'h3);
         smp(VEC[i][23:16]);
         brd(8'h74, r);
         chk($sformatf("R7 code %0d", VEC[i][23:16]), r, {16'h0, VEC[i][15:0]});
      end

      // R7 nine-bit sum: 0xF0 + 0x20 must not wrap
      bwr(8'h44, 32'hF0, 4'h1);
      bwr(8'h5C, 32'h20, 4'h1);
      bwr(8'h54, 32'h0, 4'h1);
      bwr(8'h58, 32'h0, 4'h1);
      bwr(8'h78, 32'h1111, 4'h3);
      smp(8'hFF);
      brd(8'h74, r); chk("R7 no wrap", r, 32'h0111);
      bwr(8'h44, 32'd100, 4'h1);
      bwr(8'h54, 32'd10, 4'h1);
      bwr(8'h58, 32'd20, 4'h1);
      bwr(8'h5C, 32'd30, 4'h1);

      // R8 sticky and masked clear
      bwr(8'h78, 32'h1111, 4'h3);
      smp(8'd130);
      smp(8'd0);
      brd(8'h74, r); chk("R8 sticky", r, 32'h1111);
      bwr(8'h78, 32'h0010, 4'h3);
      brd(8'h74, r); chk("R8 partial clear", r, 32'h1101);
      bwr(8'h78, 32'h1000, 4'h1);
      brd(8'h74, r); chk("R8 lane gated clear", r, 32'h1101);
      brd(8'h78, r); chk("R8 clear reads 0", r, 0);

      // R10 interrupt masking and core gating
      bwr(8'h70, 32'h0001, 4'h3); #1;
      chk("R10 irq lvl0", {31'b0, irq}, 1);
      bwr(8'h70, 32'h0010, 4'h3); #1;
      chk("R10 irq cleared lvl", {31'b0, irq}, 0);
      bwr(8'h70, 32'h1000, 4'h3); #1;
      chk("R10 irq lvl3", {31'b0, irq}, 1);
      bwr(8'h20, 32'h2, 4'h1); #1;
      chk("R10 irq off", {31'b0, irq}, 0);
      bwr(8'h20, 32'h3, 4'h1); #1;
      chk("R10 irq back on", {31'b0, irq}, 1);
      brd(8'h70, r); chk("R10 ien readback", r, 32'h1000);
      bwr(8'h20, 32'h2, 4'h1);
      bwr(8'h78, 32'h1111, 4'h3);
      smp(8'd200);
      brd(8'h74, r); chk("R10 no set while off", r, 0);
      bwr(8'h20, 32'h3, 4'h1);

      // R9 trip beats same-cycle clear
      smp(8'd130);
      addr = 8'h78; wdata = 32'h1111; be = 4'h3; we = 1'b1;
      @(negedge clk); we = 1'b0; be = '0;
      brd(8'h74, r); chk("R9 trip wins", r, 32'h1111);
      bwr(8'h78, 32'h1111, 4'h3);
      brd(8'h74, r); chk("R9 later clear", r, 0);

      // R11 unmapped
      brd(8'h30, r); chk("R11 hole 0x30", r, 0);
      brd(8'h7C, r); chk("R11 hole 0x7C", r, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule